// File: doc/BRIEF.md
# Interleaved Activate/Read Loop Generator

This block produces the repeating command stream for a current measurement in which every bank is activated and then read with auto-precharge, in interleaved order. Each loop holds four windows of four slots. Every slot issues one activate, then a read with auto-precharge to the same bank on the next cycle, then deselects. The two halves of the loop differ in which bank groups they use. Within each half, the bank numbers rotate by one position from the first window to the second.

Three spacing inputs set the timing. They give the minimum gap between activates, the four-activate window and the row cycle. From them the block derives three lengths: a slot length, a window length and a loop length. Each derived length is never shorter than the content it must hold, so a segment that would overrun its span is cut back. While `start` is high the loop runs again and again, and `loop_done_o` marks the last cycle of each pass. The command, bank-group and bank outputs are plain per-cycle control signals with no handshake. The sink is expected to take one command every clock.

Top module: `actrd_loop_gen`

## Requirements
- R1: While `start` is low, `cmd_o` is 2'b00 (deselect), `bg_o` and `ba_o` are 0 and `loop_done_o` is 0.
- R2: Command codes are 2'b00 deselect, 2'b01 activate and 2'b10 read with auto-precharge. Code 2'b11 never appears. Every activate is followed on the next cycle by a read with auto-precharge to the same bank group and bank, and every other cycle of a slot is a deselect.
- R3: The slot length is S = max(cfg_rrd, 4). Within a window, activates fall at cycle offsets 0, S, 2S and 3S. Two activates are never closer than S cycles.
- R4: The window length is W = max(cfg_faw, 4S). Window k (k = 0..3) starts at loop cycle k·W, and the cycles from 4S to W-1 of a window are deselects.
- R5: In window k, slot s (s = 0..3) uses bank group {k[1], s[0]} and bank (s + k[0]) mod 4.
- R6: The loop length is L = max(cfg_rc, 4W). Cycles 4W to L-1 are deselects. `loop_done_o` is high for exactly the cycle at loop offset L-1, and the next cycle (with `start` held) is offset 0 again.
- R7: The spacing inputs are captured on every clock edge at which `start` is low. Changes while `start` is high have no effect on the running stream.
- R8: Dropping `start` ends the stream immediately. When `start` is raised again, the first cycle is loop offset 0.
- R9: On deselect cycles `bg_o` and `ba_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run the loop while high; captures spacing while low |
| cfg_rrd | input | CW | Minimum activate-to-activate spacing, cycles |
| cfg_faw | input | CW | Four-activate window span, cycles |
| cfg_rc | input | CW | Row cycle span that the whole loop must cover, cycles |
| cmd_o | output | 2 | Command code for this cycle |
| bg_o | output | 2 | Bank group of the current command |
| ba_o | output | 2 | Bank of the current command |
| loop_done_o | output | 1 | One-cycle pulse on the last cycle of each loop |

## Verification
Two events can share one cycle: the wrap of the whole loop and the close of a window or slot. This happens when cfg_rc does not exceed 4W, so the loop ends on the last pad cycle of window 3. The same holds when cfg_faw does not exceed 4S, where window padding is cut back to nothing. The sweep deliberately includes such small cfg_rc and cfg_faw values next to large ones. Every cycle is compared with an arithmetic model of offsets, so the bench can tell whether the wrap took priority: `loop_done_o` must fall on the right cycle, and the next cycle must be an activate to bank group 0, bank 0.

// File: rtl/actrd_pkg.sv
package actrd_pkg;
  typedef enum logic [1:0] {
    CMD_DES = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RDA = 2'b10
  } cmd_e;

  localparam int unsigned SLOTS_PER_WIN = 4;
  localparam int unsigned WINS_PER_LOOP = 4;
endpackage

// File: rtl/actrd_span_calc.sv
module actrd_span_calc #(
  parameter int unsigned CW = 8,
  parameter int unsigned LW = CW + 4
) (
  input  logic [CW-1:0] rrd,
  input  logic [CW-1:0] faw,
  input  logic [CW-1:0] rc,
  output logic [LW-1:0] slot_len,
  output logic [LW-1:0] win_len,
  output logic [LW-1:0] loop_len
);
  localparam logic [LW-1:0] MIN_SLOT = LW'(4);

  logic [LW-1:0] rrd_w, faw_w, rc_w, four_slots, four_wins;

  always_comb begin
    rrd_w      = LW'(rrd);
    faw_w      = LW'(faw);
    rc_w       = LW'(rc);
    slot_len   = (rrd_w > MIN_SLOT) ? rrd_w : MIN_SLOT;
    four_slots = slot_len << 2;
    win_len    = (faw_w > four_slots) ? faw_w : four_slots;
    four_wins  = win_len << 2;
    loop_len   = (rc_w > four_wins) ? rc_w : four_wins;
  end
endmodule

// File: rtl/actrd_seq_ctr.sv
module actrd_seq_ctr #(
  parameter int unsigned LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [LW-1:0] slot_len,
  input  logic [LW-1:0] win_len,
  input  logic [LW-1:0] loop_len,
  output logic [2:0]    slot_idx,
  output logic [LW-1:0] slot_cyc,
  output logic [2:0]    win_idx,
  output logic          last_cycle
);
  logic [LW-1:0] win_cyc, loop_cyc;

  assign last_cycle = (loop_cyc == loop_len - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_idx <= '0; slot_cyc <= '0; win_idx <= '0; win_cyc <= '0; loop_cyc <= '0;
    end else if (!run || last_cycle) begin
      slot_idx <= '0; slot_cyc <= '0; win_idx <= '0; win_cyc <= '0; loop_cyc <= '0;
    end else begin
      loop_cyc <= loop_cyc + LW'(1);
      if (win_idx < 3'd4) begin
        if (win_cyc == win_len - LW'(1)) begin
          win_cyc  <= '0;
          win_idx  <= win_idx + 3'd1;
          slot_idx <= '0;
          slot_cyc <= '0;
        end else begin
          win_cyc <= win_cyc + LW'(1);
          if (slot_idx < 3'd4) begin
            if (slot_cyc == slot_len - LW'(1)) begin
              slot_cyc <= '0;
              slot_idx <= slot_idx + 3'd1;
            end else begin
              slot_cyc <= slot_cyc + LW'(1);
            end
          end
        end
      end
    end
  end

  // R4: window counter stays inside its span while a window is active
  a_r4_win_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && win_idx < 3'd4) |-> (win_cyc < win_len));
  // R6: loop counter never passes the loop length
  a_r6_loop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (loop_cyc < loop_len));
  // R3: slot phase stays inside the slot length
  a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && slot_idx < 3'd4) |-> (slot_cyc < slot_len));
endmodule

// File: rtl/actrd_bank_map.sv
module actrd_bank_map (
  input  logic [1:0] win,
  input  logic [1:0] slot,
  output logic [1:0] bg,
  output logic [1:0] ba
);
  always_comb begin
    bg = {win[1], slot[0]};
    ba = slot + {1'b0, win[0]};
  end
endmodule

// File: rtl/actrd_loop_gen.sv
module actrd_loop_gen #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cfg_rrd,
  input  logic [CW-1:0] cfg_faw,
  input  logic [CW-1:0] cfg_rc,
  output logic [1:0]    cmd_o,
  output logic [1:0]    bg_o,
  output logic [1:0]    ba_o,
  output logic          loop_done_o
);
  import actrd_pkg::*;

  localparam int unsigned LW = CW + 4;

  logic [CW-1:0] rrd_q, faw_q, rc_q;
  logic [LW-1:0] slot_len, win_len, loop_len, slot_cyc;
  logic [2:0]    slot_idx, win_idx;
  logic          last_cycle, in_slot;
  logic [1:0]    map_bg, map_ba;
  cmd_e          cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q <= '0; faw_q <= '0; rc_q <= '0;
    end else if (!start) begin
      rrd_q <= cfg_rrd; faw_q <= cfg_faw; rc_q <= cfg_rc;
    end
  end

  actrd_span_calc #(.CW(CW), .LW(LW)) u_span (
    .rrd(rrd_q), .faw(faw_q), .rc(rc_q),
    .slot_len(slot_len), .win_len(win_len), .loop_len(loop_len)
  );

  actrd_seq_ctr #(.LW(LW)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(start),
    .slot_len(slot_len), .win_len(win_len), .loop_len(loop_len),
    .slot_idx(slot_idx), .slot_cyc(slot_cyc), .win_idx(win_idx),
    .last_cycle(last_cycle)
  );

  actrd_bank_map u_map (
    .win(win_idx[1:0]), .slot(slot_idx[1:0]), .bg(map_bg), .ba(map_ba)
  );

  always_comb begin
    in_slot = start && (win_idx < 3'd4) && (slot_idx < 3'd4);
    if (in_slot && slot_cyc == '0)             cmd = CMD_ACT;
    else if (in_slot && slot_cyc == LW'(1))    cmd = CMD_RDA;
    else                                       cmd = CMD_DES;
  end

  assign cmd_o       = cmd;
  assign bg_o        = (cmd == CMD_DES) ? 2'b00 : map_bg;
  assign ba_o        = (cmd == CMD_DES) ? 2'b00 : map_ba;
  assign loop_done_o = start && last_cycle;

  // activate spacing monitor
  logic [LW-1:0] act_gap;
  logic          act_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_gap <= '0; act_seen <= 1'b0;
    end else if (!start) begin
      act_gap <= '0; act_seen <= 1'b0;
    end else if (cmd_o == 2'b01) begin
      act_gap <= LW'(1); act_seen <= 1'b1;
    end else if (act_gap != '1) begin
      act_gap <= act_gap + LW'(1);
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> (cmd_o == 2'b00 && !loop_done_o));
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o != 2'b11);
  a_r2_act_then_rda: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'b01) |=> (!start || (cmd_o == 2'b10 && $stable(bg_o) && $stable(ba_o))));
  a_r3_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'b01 && act_seen) |-> (act_gap >= slot_len));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done_o |=> !loop_done_o);
  a_r6_done_on_des: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done_o |-> (cmd_o == 2'b00));
  a_r9_des_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 2'b00) |-> (bg_o == 2'b00 && ba_o == 2'b00));
endmodule

// File: tb/test_actrd_loop_gen.sv
module test_actrd_loop_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] cfg_rrd = '0, cfg_faw = '0, cfg_rc = '0;
  logic [1:0] cmd_o, bg_o, ba_o;
  logic loop_done_o;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  actrd_loop_gen #(.CW(CW)) i_actrd_loop_gen (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_rrd(cfg_rrd), .cfg_faw(cfg_faw), .cfg_rc(cfg_rc),
    .cmd_o(cmd_o), .bg_o(bg_o), .ba_o(ba_o), .loop_done_o(loop_done_o)
  );

  function automatic int mx(int a, int b); return (a > b) ? a : b; endfunction

  // expected {done, cmd, bg, ba} at loop offset c
  function automatic logic [6:0] model(int c, int s, int w, int l);
    int k, r, sl, o;
    logic [1:0] cmd, bg, ba;
    cmd = 2'b00; bg = 2'b00; ba = 2'b00;
    if (c < 4*w) begin
      k = c / w; r = c % w;
      if (r < 4*s) begin
        sl = r / s; o = r % s;
        if (o < 2) begin
          cmd = (o == 0) ? 2'b01 : 2'b10;
          bg  = 2'(((k >> 1) << 1) | (sl & 1));
          ba  = 2'((sl + (k & 1)) & 3);
        end
      end
    end
    return {(c == l - 1), cmd, bg, ba};
  endfunction

  task automatic check(string tag, logic [6:0] exp);
    logic [6:0] act;
    act = {loop_done_o, cmd_o, bg_o, ba_o};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got done/cmd/bg/ba=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // run one configuration; optional mid-run config change or start drop
  task automatic run_cfg(int rrd, int faw, int rc, int ncyc, int mode);
    int s, w, l, c;
    s = mx(rrd, 4); w = mx(faw, 4*s); l = mx(rc, 4*w);
    @(negedge clk);
    start = 1'b0; cfg_rrd = CW'(rrd); cfg_faw = CW'(faw); cfg_rc = CW'(rc);
    @(negedge clk);
    #1 check("R1", 7'b0);
    c = 0;
    for (int i = 0; i < ncyc; i++) begin
      start = 1'b1;
      if (mode == 1 && i == 3) begin
        cfg_rrd = CW'(rrd + 7); cfg_faw = CW'(faw + 9); cfg_rc = CW'(rc + 11);
      end
      if (mode == 2 && i == l / 2) begin
        start = 1'b0;
        #1 check("R8", 7'b0);
        @(negedge clk);
        start = 1'b1; c = 0;
      end
      #1 check((mode == 1) ? "R7" : ((mode == 2) ? "R8" : "R2/R3/R4/R5/R6/R9"), model(c, s, w, l));
      c = (c + 1) % l;
      @(negedge clk);
    end
    start = 1'b0;
    cfg_rrd = CW'(rrd); cfg_faw = CW'(faw); cfg_rc = CW'(rc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int rrds[4] = '{2, 4, 5, 6};
    int faws[4] = '{10, 16, 20, 27};
    int rcs[4]  = '{30, 64, 100, 130};
    #(CLK_PERIOD * 2 + 3);
    check("R1", 7'b0);
    rst_n = 1'b1;
    // full sweep: two loops plus a few cycles per configuration
    foreach (rrds[a]) foreach (faws[b]) foreach (rcs[d]) begin
      int s, w, l;
      s = mx(rrds[a], 4); w = mx(faws[b], 4*s); l = mx(rcs[d], 4*w);
      run_cfg(rrds[a], faws[b], rcs[d], 2*l + 3, 0);
    end
    run_cfg(5, 21, 90, 200, 1);  // R7: spacing changes while running ignored
    run_cfg(6, 16, 64, 150, 2);  // R8: drop start mid-loop then restart
    @(negedge clk);
    #1 check("R1", 7'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule